// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It does not own a counter. It watches a shared free-running 16-bit count value and a single-cycle strobe that marks the counter wrapping. In capture mode it latches the count when a chosen edge appears on its input pin. In compare mode it drives an output pin that can be set, cleared or toggled on a count match. It can also toggle on every wrap, which gives unbuffered pulse-width modulation. A full-duty override can pin that waveform high.

Software reaches the channel through an 8-bit register port with three locations. The first holds the control bits and the event flag. The other two hold the upper and lower halves of the 16-bit channel value. Byte-wise access keeps the 16-bit value coherent. Reading the upper half holds off new captures until the lower half is read. Writing the upper half holds off compare matches until the lower half is written.

Top module: `tmr_chan`

## Requirements
- R1: A synchronous active-high reset clears the mode, edge/action, wrap-toggle and full-duty bits, the event flag, both byte locks and the internal output level, so `pin_out` is 0. The channel value is not reset.
- R2: Mode field value 00 selects capture mode; 01, 10 and 11 all select compare mode. In capture mode `pin_out` is 0.
- R3: In capture mode, the edge field selects the triggering edge of `pin_in`: 01 rising, 10 falling, 11 either, 00 none. On a selected edge, the channel value takes the `cnt_val` of that same cycle and the flag is set.
- R4: In capture mode, a read of address 1 blocks captures, starting in that cycle, until a read of address 2 has completed. A blocked edge changes neither the value nor the flag.
- R5: In compare mode, when `cnt_val` equals the channel value, the flag is set and the action field is applied to the output level, visible on `pin_out` one cycle later. Action encodings: 01 toggle, 10 clear, 11 set, 00 no change.
- R6: In compare mode, a write of address 1 blocks matches, including flag setting, until address 2 has been written.
- R7: With the wrap-toggle bit set in compare mode, each `cnt_ovf` strobe inverts the output level. With the bit clear, or in capture mode, the strobe leaves the level unchanged.
- R8: When a wrap toggle and a compare match occur in the same cycle, the toggle is applied and the match action is discarded.
- R9: The full-duty bit is sampled only at `cnt_ovf`. While the sampled value is 1 and the wrap-toggle bit is set in compare mode, `pin_out` is held at 1. Setting or clearing the bit therefore takes effect at the next wrap.
- R10: The flag clears only when a control-register write with bit 7 = 0 follows a control-register read that returned the flag as 1. A write without that prior read leaves the flag set.
- R11: Register map: address 0 is control, with bit 7 flag, bits 5:4 mode, bits 3:2 edge/action, bit 1 wrap-toggle, bit 0 full-duty, and bit 6 reading 0. Address 1 is the value's bits 15:8, address 2 is bits 7:0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared free-running count |
| cnt_ovf | input | 1 | One-cycle strobe when the count wraps |
| pin_in | input | 1 | Capture input (already synchronized) |
| pin_out | output | 1 | Compare/PWM output |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |

## Verification
The bench fires a wrap and a set-on-match in the same cycle. A design that lets the match win would drive the output high instead of inverting it. The bench writes the full-duty bit partway through a period and later clears it. A design without the one-period latency would jump high at once or drop early, while the forced level should persist for the rest of that period. The bench interleaves byte accesses with edges and matches. A design without the locks would capture a new value between the two half reads, or match against a half-written value. It also checks that the flag survives a clearing write that was not preceded by a read.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_VALHI = 2'd1,
        REG_VALLO = 2'd2,
        REG_SPARE = 2'd3
    } addr_e;

    // Control fields; packed order matches the low six bits of the control byte
    typedef struct packed {
        logic [1:0] mode;   // 00 capture, otherwise compare
        logic [1:0] sel;    // edge select (capture) or match action (compare)
        logic       tov;    // invert output on counter wrap
        logic       maxd;   // full-duty request
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic is_capture(ctrl_t c);
        return c.mode == 2'b00;
    endfunction

    function automatic logic edge_selected(logic [1:0] s, logic rise, logic fall);
        return (s[0] & rise) | (s[1] & fall);
    endfunction

    function automatic logic apply_action(logic [1:0] a, logic cur);
        case (a)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  logic [1:0] sel,
    output logic       hit
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_in;
    end

    assign hit = edge_selected(sel, pin_in & ~pin_q, ~pin_in & pin_q);
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_chan_pkg::*;
#(
    parameter int BW = 8,
    localparam int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic [CW-1:0] cnt_val,
    input  logic          cap_hit,
    input  logic          match,
    output ctrl_t         ctrl,
    output logic [CW-1:0] chval,
    output logic          flag,
    output logic          cap_fire,
    output logic          cap_block,
    output logic          cmp_block
);
    logic ctrl_wr, ctrl_rd, hi_wr, lo_wr, hi_rd, lo_rd;
    logic cap_lock, cmp_lock, clr_arm;
    logic unused_bits;

    assign ctrl_wr = bus_sel & bus_wr & (addr_e'(bus_addr) == REG_CTRL);
    assign ctrl_rd = bus_sel & bus_rd & (addr_e'(bus_addr) == REG_CTRL);
    assign hi_wr   = bus_sel & bus_wr & (addr_e'(bus_addr) == REG_VALHI);
    assign lo_wr   = bus_sel & bus_wr & (addr_e'(bus_addr) == REG_VALLO);
    assign hi_rd   = bus_sel & bus_rd & (addr_e'(bus_addr) == REG_VALHI);
    assign lo_rd   = bus_sel & bus_rd & (addr_e'(bus_addr) == REG_VALLO);
    assign unused_bits = &{1'b0, bus_wdata[BW-2:CTRL_W]};

    // Locks take hold in the cycle of the high-byte access itself
    assign cap_block = cap_lock | hi_rd;
    assign cmp_block = cmp_lock | hi_wr;
    assign cap_fire  = is_capture(ctrl) & cap_hit & ~cap_block;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            cap_lock <= 1'b0;
            cmp_lock <= 1'b0;
            clr_arm  <= 1'b0;
            flag     <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);

            if (hi_rd && is_capture(ctrl))       cap_lock <= 1'b1;
            else if (lo_rd)                      cap_lock <= 1'b0;

            if (hi_wr && !is_capture(ctrl))      cmp_lock <= 1'b1;
            else if (lo_wr)                      cmp_lock <= 1'b0;

            if (ctrl_wr)                         clr_arm <= 1'b0;
            else if (ctrl_rd && flag)            clr_arm <= 1'b1;

            if (cap_fire || match)               flag <= 1'b1;
            else if (ctrl_wr && clr_arm && !bus_wdata[BW-1]) flag <= 1'b0;
        end
    end

    // Channel value deliberately has no reset
    always_ff @(posedge clk) begin
        if (cap_fire) begin
            chval <= cnt_val;
        end else begin
            if (hi_wr) chval[CW-1:BW] <= bus_wdata;
            if (lo_wr) chval[BW-1:0]  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr_e'(bus_addr))
            REG_CTRL: begin
                bus_rdata[BW-1]       = flag;
                bus_rdata[CTRL_W-1:0] = ctrl;
            end
            REG_VALHI: bus_rdata = chval[CW-1:BW];
            REG_VALLO: bus_rdata = chval[BW-1:0];
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_chan_wave.sv
module tmr_chan_wave
    import tmr_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_ovf,
    input  logic [CW-1:0] chval,
    input  logic          cmp_block,
    output logic          match,
    output logic          lvl,
    output logic          maxd_eff,
    output logic          pin_out
);
    logic cmp_mode, wrap_tog;

    assign cmp_mode = ~is_capture(ctrl);
    assign match    = cmp_mode & ~cmp_block & (cnt_val == chval);
    assign wrap_tog = cmp_mode & ctrl.tov & cnt_ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl      <= 1'b0;
            maxd_eff <= 1'b0;
        end else begin
            // Wrap toggle outranks the match action
            if (wrap_tog)    lvl <= ~lvl;
            else if (match)  lvl <= apply_action(ctrl.sel, lvl);
            if (cnt_ovf)     maxd_eff <= ctrl.maxd;
        end
    end

    assign pin_out = cmp_mode & ((ctrl.tov & maxd_eff) | lvl);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int BW = 8,
    localparam int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_ovf,
    input  logic          pin_in,
    output logic          pin_out,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata
);
    ctrl_t         ctrl;
    logic [CW-1:0] chval;
    logic          flag, cap_hit, cap_fire, cap_block, cmp_block;
    logic          match, lvl, maxd_eff;

    tmr_chan_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .sel    (ctrl.sel),
        .hit    (cap_hit)
    );

    tmr_chan_regs #(.BW(BW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_val),
        .cap_hit   (cap_hit),
        .match     (match),
        .ctrl      (ctrl),
        .chval     (chval),
        .flag      (flag),
        .cap_fire  (cap_fire),
        .cap_block (cap_block),
        .cmp_block (cmp_block)
    );

    tmr_chan_wave #(.CW(CW)) u_wave (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .cnt_val   (cnt_val),
        .cnt_ovf   (cnt_ovf),
        .chval     (chval),
        .cmp_block (cmp_block),
        .match     (match),
        .lvl       (lvl),
        .maxd_eff  (maxd_eff),
        .pin_out   (pin_out)
    );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_chan_pkg::*;
#(
    parameter int BW = 8,
    localparam int CW = 2 * BW
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cnt_val,
    input logic          cnt_ovf,
    input logic          pin_out,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input ctrl_t         ctrl,
    input logic [CW-1:0] chval,
    input logic          flag,
    input logic          cap_fire,
    input logic          cap_block,
    input logic          cmp_block,
    input logic          match,
    input logic          lvl,
    input logic          maxd_eff
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (ctrl == '0) && !flag && !pin_out); // R1

    AST_CAPTURE_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == 2'b00) |-> !pin_out); // R2

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> (chval == $past(cnt_val)) && flag); // R3

    AST_CAPTURE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (cap_block && !(bus_sel && bus_wr && bus_addr != 2'd0)) |=> $stable(chval)); // R4

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        match |=> flag); // R5

    AST_COMPARE_LOCK: assert property (@(posedge clk) disable iff (rst)
        cmp_block |-> !match); // R6

    AST_CAPTURE_LEVEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == 2'b00) |=> $stable(lvl)); // R7

    AST_WRAP_WINS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode != 2'b00 && ctrl.tov && cnt_ovf) |=> (lvl != $past(lvl))); // R8

    AST_FULL_DUTY_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !cnt_ovf |=> $stable(maxd_eff)); // R9

    AST_FLAG_CLEAR_PATH: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(bus_sel && bus_wr && bus_addr == 2'd0)); // R10
endmodule

bind tmr_chan tmr_chan_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_val   (cnt_val),
    .cnt_ovf   (cnt_ovf),
    .pin_out   (pin_out),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ctrl      (ctrl),
    .chval     (chval),
    .flag      (flag),
    .cap_fire  (cap_fire),
    .cap_block (cap_block),
    .cmp_block (cmp_block),
    .match     (match),
    .lvl       (lvl),
    .maxd_eff  (maxd_eff)
);

// File: tb/tmr_chan_test.sv
`timescale 1ns/1ps
module tmr_chan_test;
    localparam logic [15:0] IDLE = 16'hEEEE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt = IDLE;
    logic        ovf = 1'b0;
    logic        pin = 1'b0;
    logic        pout;
    logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [7:0]  v;
    int          nvec = 0;
    int          nbad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_chan uut (
        .clk(clk), .rst(rst), .cnt_val(cnt), .cnt_ovf(ovf),
        .pin_in(pin), .pin_out(pout),
        .bus_sel(sel), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 1'b0; rd = 1'b0;
    endtask

    // One counter cycle; returns at the negedge after the edge that used it
    task automatic step(input logic [15:0] c, input logic o, input logic p);
        @(negedge clk); cnt = c; ovf = o; pin = p;
        @(negedge clk); cnt = IDLE; ovf = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 output after reset", {15'd0, pout}, 16'd0);
        bus_rd(2'd0, v); chk("R1 control after reset", {8'd0, v}, 16'h0000);
        bus_rd(2'd3, v); chk("R11 spare address", {8'd0, v}, 16'h0000);
    endtask

    task automatic t_capture;
        bus_wr(2'd0, 8'h84);                 // capture, rising
        step(16'h1234, 1'b0, 1'b1);
        step(16'h2222, 1'b0, 1'b0);          // falling not selected
        bus_rd(2'd1, v); chk("R3 rising capture hi", {8'd0, v}, 16'h0012);
        bus_rd(2'd2, v); chk("R3 rising capture lo", {8'd0, v}, 16'h0034);
        chk("R2 capture mode output low", {15'd0, pout}, 16'd0);
        bus_rd(2'd0, v); chk("R11 control with flag", {8'd0, v}, 16'h0084);
        bus_wr(2'd0, 8'h04);
        bus_rd(2'd0, v); chk("R10 flag cleared after read", {8'd0, v}, 16'h0004);
        bus_wr(2'd0, 8'h8C);                 // both edges
        step(16'h4321, 1'b0, 1'b1);
        bus_rd(2'd1, v); chk("R3 both rise hi", {8'd0, v}, 16'h0043);
        bus_rd(2'd2, v); chk("R3 both rise lo", {8'd0, v}, 16'h0021);
        step(16'h5678, 1'b0, 1'b0);
        bus_rd(2'd1, v); chk("R3 both fall hi", {8'd0, v}, 16'h0056);
        bus_rd(2'd2, v); chk("R3 both fall lo", {8'd0, v}, 16'h0078);
        bus_wr(2'd0, 8'h88);                 // falling only
        step(16'h1111, 1'b0, 1'b1);
        step(16'h2468, 1'b0, 1'b0);
        bus_rd(2'd1, v); chk("R3 falling hi", {8'd0, v}, 16'h0024);
        bus_rd(2'd2, v); chk("R3 falling lo", {8'd0, v}, 16'h0068);
    endtask

    task automatic t_caplock;
        bus_wr(2'd0, 8'h8C);
        step(16'h0A0B, 1'b0, 1'b1);
        bus_rd(2'd1, v); chk("R4 hi before lock", {8'd0, v}, 16'h000A);
        step(16'h0C0D, 1'b0, 1'b0);          // blocked edge
        bus_rd(2'd2, v); chk("R4 lo held while locked", {8'd0, v}, 16'h000B);
        step(16'h0E0F, 1'b0, 1'b1);
        bus_rd(2'd1, v); chk("R4 capture resumes hi", {8'd0, v}, 16'h000E);
        bus_rd(2'd2, v); chk("R4 capture resumes lo", {8'd0, v}, 16'h000F);
    endtask

    task automatic t_flagclr;
        bus_wr(2'd0, 8'h0C);                 // no prior read: no clear
        bus_rd(2'd0, v); chk("R10 unarmed write keeps flag", {8'd0, v}, 16'h008C);
        bus_wr(2'd0, 8'h0C);
        bus_rd(2'd0, v); chk("R10 armed write clears flag", {8'd0, v}, 16'h000C);
    endtask

    task automatic t_compare;
        bus_wr(2'd0, 8'h94);                 // compare, toggle
        bus_wr(2'd1, 8'h01);
        bus_wr(2'd2, 8'h00);
        chk("R5 no match yet", {15'd0, pout}, 16'd0);
        step(16'h0100, 1'b0, 1'b0);
        chk("R5 toggle on match", {15'd0, pout}, 16'd1);
        bus_rd(2'd0, v); chk("R5 match sets flag", {8'd0, v}, 16'h0094);
        bus_wr(2'd0, 8'h18);                 // clear action, clears flag
        step(16'h0100, 1'b0, 1'b0);
        chk("R5 clear on match", {15'd0, pout}, 16'd0);
        bus_wr(2'd0, 8'h9C);
        step(16'h0100, 1'b0, 1'b0);
        chk("R5 set on match", {15'd0, pout}, 16'd1);
        bus_wr(2'd0, 8'h90);
        step(16'h0100, 1'b0, 1'b0);
        chk("R5 no action on match", {15'd0, pout}, 16'd1);
        bus_wr(2'd0, 8'hA4);                 // mode 10
        step(16'h0100, 1'b0, 1'b0);
        chk("R2 mode 10 is compare", {15'd0, pout}, 16'd0);
        bus_wr(2'd0, 8'hB4);                 // mode 11
        step(16'h0100, 1'b0, 1'b0);
        chk("R2 mode 11 is compare", {15'd0, pout}, 16'd1);
    endtask

    task automatic t_cmplock;
        bus_wr(2'd0, 8'h94);
        bus_rd(2'd0, v);
        bus_wr(2'd0, 8'h14);                 // clear flag
        bus_rd(2'd0, v); chk("R10 flag cleared before lock test", {8'd0, v}, 16'h0014);
        bus_wr(2'd1, 8'h02);                 // value 0x0200, lock held
        step(16'h0200, 1'b0, 1'b0);
        chk("R6 no toggle while locked", {15'd0, pout}, 16'd1);
        bus_rd(2'd0, v); chk("R6 no flag while locked", {8'd0, v}, 16'h0014);
        bus_wr(2'd2, 8'h00);
        step(16'h0200, 1'b0, 1'b0);
        chk("R6 match after low write", {15'd0, pout}, 16'd0);
        bus_rd(2'd0, v); chk("R6 flag after unlock", {8'd0, v}, 16'h0094);
    endtask

    task automatic t_tov;
        bus_wr(2'd0, 8'h9A);                 // compare, clear, wrap toggle
        step(16'h0000, 1'b1, 1'b0);
        chk("R7 wrap toggles high", {15'd0, pout}, 16'd1);
        step(16'h0200, 1'b0, 1'b0);
        chk("R5 match clears", {15'd0, pout}, 16'd0);
        step(16'h0000, 1'b1, 1'b0);
        chk("R7 wrap toggles again", {15'd0, pout}, 16'd1);
        bus_wr(2'd0, 8'h9E);                 // set-on-match
        step(16'h0200, 1'b1, 1'b0);          // wrap and match together
        chk("R8 wrap beats set-on-match", {15'd0, pout}, 16'd0);
        bus_wr(2'd0, 8'h90);                 // wrap toggle off
        step(16'h0000, 1'b1, 1'b0);
        chk("R7 no toggle when bit clear", {15'd0, pout}, 16'd0);
        bus_wr(2'd0, 8'h82);                 // capture mode, wrap bit set
        step(16'h0000, 1'b1, 1'b0);
        chk("R7 capture mode output", {15'd0, pout}, 16'd0);
        bus_wr(2'd0, 8'h90);                 // back to compare, shows level
        chk("R7 capture mode left level alone", {15'd0, pout}, 16'd0);
    endtask

    task automatic t_maxd;
        bus_wr(2'd0, 8'h9A);
        step(16'h0000, 1'b1, 1'b0);
        chk("R7 period start high", {15'd0, pout}, 16'd1);
        step(16'h0200, 1'b0, 1'b0);
        chk("R5 period low after match", {15'd0, pout}, 16'd0);
        bus_wr(2'd0, 8'h9B);                 // full duty requested mid-period
        chk("R9 not immediate on set", {15'd0, pout}, 16'd0);
        step(16'h0200, 1'b0, 1'b0);
        chk("R9 still normal before wrap", {15'd0, pout}, 16'd0);
        step(16'h0000, 1'b1, 1'b0);
        chk("R9 forced at wrap", {15'd0, pout}, 16'd1);
        step(16'h0200, 1'b0, 1'b0);
        chk("R9 match masked while forced", {15'd0, pout}, 16'd1);
        step(16'h0000, 1'b1, 1'b0);
        step(16'h0200, 1'b0, 1'b0);
        bus_wr(2'd0, 8'h9A);                 // release requested
        chk("R9 held after clear", {15'd0, pout}, 16'd1);
        step(16'h0200, 1'b0, 1'b0);
        chk("R9 held until wrap", {15'd0, pout}, 16'd1);
        step(16'h0000, 1'b1, 1'b0);
        chk("R9 wrap after release", {15'd0, pout}, 16'd1);
        step(16'h0200, 1'b0, 1'b0);
        chk("R9 released, match clears", {15'd0, pout}, 16'd0);
        bus_wr(2'd0, 8'h99);                 // full duty without wrap toggle
        step(16'h0000, 1'b1, 1'b0);
        chk("R9 no force without wrap toggle", {15'd0, pout}, 16'd0);
    endtask

    initial begin
        t_reset;
        t_capture;
        t_caplock;
        t_flagclr;
        t_compare;
        t_cmplock;
        t_tov;
        t_maxd;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule